// File: doc/BRIEF.md
# Motion-Activity Amplifier Enable Watchdog

This block drives one active-high enable line that switches four motor amplifiers on or off together. It watches the commanded destination positions of several axes (three by default). On each timeslice strobe it compares the current destinations with the values it recorded at the last detected motion. If any axis differs, it records the new destinations, raises the enable and restarts an idle counter.

The idle counter advances on a timebase tick. When it reaches a programmable number of ticks with no further motion, the enable drops on its own. The default is ten seconds at the configured tick rate. Two override inputs sit on top of this. A force-enable holds the line high whatever the counter says. A force-disable holds it low and wins over every other input. While the line is forced, motion detection and the counter keep running.

Top module: `amp_enable_watchdog`

## Requirements
- R1: After reset `amp_en_o` is low, every stored destination is zero and the idle counter is parked at the timeout. A strobe with all destinations equal to zero therefore does not raise the enable.
- R2: A strobe in which any axis destination differs from its stored value raises `amp_en_o` in the cycle after that clock edge, and stores all current destinations.
- R3: Destination changes presented without a strobe are ignored and do not change `amp_en_o`.
- R4: A strobe whose destinations all match the stored values does not restart the idle counter.
- R5: After the last motion, `amp_en_o` stays high until IDLE_TICKS clock edges with `tick_i` high have been counted. It falls right after the edge that counts the IDLE_TICKS-th tick. Cycles without `tick_i` do not advance the count.
- R6: A motion strobe in the same cycle as a tick restarts the counter at zero; motion has priority over counting.
- R7: While `force_en_i` is high and `force_dis_i` is low, `amp_en_o` is high, including after a timeout.
- R8: `force_dis_i` high forces `amp_en_o` low in that same cycle over all other inputs. Motion seen while it is high is still recorded, so the timed enable shows once it is released.
- R9: The idle counter saturates at the timeout. Any number of further ticks keeps `amp_en_o` low and never wraps round to enable it.
- R10: Axis i occupies bits [i*POS_W +: POS_W] of `dest_i`. A change confined to any single axis, including only its top bit, counts as motion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase tick, one cycle per idle-count step |
| strobe_i | input | 1 | Timeslice strobe; destinations compared when high |
| dest_i | input | NUM_AXES*POS_W | Packed commanded destinations, axis i at [i*POS_W +: POS_W] |
| force_en_i | input | 1 | Hold enable high |
| force_dis_i | input | 1 | Hold enable low, highest priority |
| amp_en_o | output | 1 | Shared amplifier enable, high = on |

## Verification
The assertions assume that every input is synchronous to `clk_i` and has a known value from the first edge after reset. They also assume `tick_i` and `strobe_i` are plain level samples: a long high stretch counts as one event per cycle, not one per pulse. The stimulus changes all inputs only on the falling clock edge and never leaves them unknown. Random strobes, ticks and single-axis changes are mixed with force pulses, so motion, counting, saturation and the overrides all occur in the same run. The bench shrinks the timeout to a few dozen ticks. Its model then covers expiry many times, and it drives more ticks past saturation than the counter width could hold.

// File: rtl/amp_wd_pkg.sv
package amp_wd_pkg;
  // Output priority: disable override, then enable override, then timed state.
  function automatic logic gate_enable(input logic force_dis, input logic force_en,
                                       input logic running);
    if (force_dis) return 1'b0;
    if (force_en) return 1'b1;
    return running;
  endfunction
endpackage

// File: rtl/axis_change_detect.sv
module axis_change_detect #(
  parameter int NUM_AXES = 3,
  parameter int POS_W    = 32
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      strobe_i,
  input  logic [NUM_AXES*POS_W-1:0] dest_i,
  output logic                      moved_o
);
  localparam int BUS_W = NUM_AXES * POS_W;

  logic [NUM_AXES-1:0] diff;
  logic [BUS_W-1:0]    ref_q;

  for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
    assign diff[a] = dest_i[a*POS_W +: POS_W] != ref_q[a*POS_W +: POS_W];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ref_q[a*POS_W +: POS_W] <= '0;
      else if (moved_o) ref_q[a*POS_W +: POS_W] <= dest_i[a*POS_W +: POS_W];
    end
  end

  assign moved_o = strobe_i && (|diff);

  assert_ref_latch_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    moved_o |=> ref_q == $past(dest_i));
  assert_no_strobe_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> $stable(ref_q));
endmodule

// File: rtl/idle_timer.sv
module idle_timer #(
  parameter int IDLE_TICKS = 10000,
  parameter int CNT_W      = $clog2(IDLE_TICKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic tick_i,
  output logic running_o
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(IDLE_TICKS);

  logic [CNT_W-1:0] cnt_q;

  // Parked at LIMIT means expired / stopped.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= LIMIT;
    else if (restart_i) cnt_q <= '0;
    else if (tick_i && cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign running_o = cnt_q != LIMIT;

  assert_saturate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIMIT);
  assert_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> cnt_q == '0);
  assert_no_tick_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart_i && !tick_i) |=> $stable(cnt_q));
  assert_drop_on_tick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(running_o) |-> $past(tick_i));
endmodule

// File: rtl/amp_enable_watchdog.sv
module amp_enable_watchdog
  import amp_wd_pkg::*;
#(
  parameter int NUM_AXES   = 3,
  parameter int POS_W      = 32,
  parameter int TICK_HZ    = 1000,
  parameter int IDLE_SEC   = 10,
  parameter int IDLE_TICKS = TICK_HZ * IDLE_SEC
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      tick_i,
  input  logic                      strobe_i,
  input  logic [NUM_AXES*POS_W-1:0] dest_i,
  input  logic                      force_en_i,
  input  logic                      force_dis_i,
  output logic                      amp_en_o
);
  localparam int CNT_W = $clog2(IDLE_TICKS + 1);

  logic moved;
  logic running;

  axis_change_detect #(.NUM_AXES(NUM_AXES), .POS_W(POS_W)) u_detect (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strobe_i(strobe_i),
    .dest_i  (dest_i),
    .moved_o (moved)
  );

  idle_timer #(.IDLE_TICKS(IDLE_TICKS), .CNT_W(CNT_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(moved),
    .tick_i   (tick_i),
    .running_o(running)
  );

  assign amp_en_o = gate_enable(force_dis_i, force_en_i, running);

  assert_motion_en_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    moved |=> (amp_en_o || force_dis_i));
  assert_dis_prio_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_dis_i |-> !amp_en_o);
  assert_force_on_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_en_i && !force_dis_i) |-> amp_en_o);
endmodule

// File: tb/sim_amp_enable_watchdog.sv
module sim_amp_enable_watchdog;
  localparam int NUM_AXES = 3;
  localparam int POS_W    = 16;
  localparam int TICK_HZ  = 2;
  localparam int IDLE_SEC = 10;
  localparam int IDLE     = TICK_HZ * IDLE_SEC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, strobe = 1'b0, fen = 1'b0, fdis = 1'b0;
  logic [NUM_AXES*POS_W-1:0] dest = '0;
  logic amp_en;

  int checks = 0, errors = 0;
  logic [POS_W-1:0] ref_m [NUM_AXES];
  int cnt_m;

  always #10 clk = ~clk;

  amp_enable_watchdog #(.NUM_AXES(NUM_AXES), .POS_W(POS_W), .TICK_HZ(TICK_HZ),
                        .IDLE_SEC(IDLE_SEC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .strobe_i(strobe), .dest_i(dest),
    .force_en_i(fen), .force_dis_i(fdis), .amp_en_o(amp_en));

  function automatic logic exp_en();
    if (fdis) return 1'b0;
    if (fen) return 1'b1;
    return cnt_m < IDLE;
  endfunction

  task automatic check(input string tag, input logic exp);
    checks++;
    if (amp_en !== exp) begin
      errors++;
      $display("FAIL %s amp_en_o=%b expected=%b t=%0t", tag, amp_en, exp, $time);
    end
  endtask

  // Apply inputs at negedge, update model at posedge, sample mid-cycle.
  task automatic step(input logic s, input logic t, input logic [NUM_AXES*POS_W-1:0] d,
                      input logic fe, input logic fd, input string tag);
    logic mv;
    @(negedge clk);
    strobe = s; tick = t; dest = d; fen = fe; fdis = fd;
    @(posedge clk);
    mv = 1'b0;
    for (int a = 0; a < NUM_AXES; a++)
      if (s && d[a*POS_W +: POS_W] != ref_m[a]) mv = 1'b1;
    if (mv) begin
      for (int a = 0; a < NUM_AXES; a++) ref_m[a] = d[a*POS_W +: POS_W];
      cnt_m = 0;
    end else if (t && cnt_m < IDLE) cnt_m++;
    #5;
    check(tag, exp_en());
  endtask

  initial begin
    #(20 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [NUM_AXES*POS_W-1:0] d;
    void'($urandom(32'h5eed));
    for (int a = 0; a < NUM_AXES; a++) ref_m[a] = '0;
    cnt_m = IDLE;
    repeat (3) @(posedge clk);
    #5 check("R1 reset", 1'b0);
    @(negedge clk) rst_n = 1'b1;
    step(1, 0, '0, 0, 0, "R1 zero strobe");
    d = '0; d[POS_W +: POS_W] = 16'h0042;
    step(0, 0, d, 0, 0, "R3 no strobe");
    step(0, 1, d, 0, 0, "R3 no strobe tick");
    step(1, 0, d, 0, 0, "R2 motion");
    for (int i = 0; i < IDLE - 1; i++) begin
      step(0, 1, d, 0, 0, "R5 counting");
      step(0, 0, d, 0, 0, "R5 idle cycle");
      if (i == 5) step(1, 0, d, 0, 0, "R4 same strobe");
    end
    step(0, 1, d, 0, 0, "R5 expiry");
    for (int i = 0; i < 70; i++) step(0, 1, d, 0, 0, "R9 saturate");
    step(0, 0, d, 1, 0, "R7 force on");
    step(0, 0, d, 1, 1, "R8 dis over en");
    for (int a = 0; a < NUM_AXES; a++) begin
      d[a*POS_W + POS_W-1] = ~d[a*POS_W + POS_W-1];
      step(1, 1, d, 0, 0, "R10 single axis top bit");
      step(0, 1, d, 0, 0, "R6 restart then count");
    end
    d[7:0] = d[7:0] + 8'd3;
    step(1, 0, d, 0, 1, "R8 motion while off");
    step(0, 0, d, 0, 0, "R8 released");
    for (int i = 0; i < 3000; i++) begin
      logic s, t, fe, fd;
      int ax;
      s = ($urandom % 2) == 0;
      t = ($urandom % 10) < 3;
      fe = ($urandom % 20) == 0;
      fd = ($urandom % 20) == 0;
      if (($urandom % 8) == 0) begin
        ax = $urandom % NUM_AXES;
        d[ax*POS_W +: POS_W] = POS_W'($urandom);
      end
      step(s, t, d, fe, fd, "R2/R5 random");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule